// File: doc/BRIEF.md
# Slow Clock Loss Detector

This block watches a slow, free-running clock and reports whether it is still toggling. A faster reference clock, which never stops, drives all of the logic. The slow clock is treated as a plain asynchronous data input. It passes through a short synchronizer chain. A level change is recognised when the synchronized sample differs from the sample taken one reference cycle earlier.

There are two registered results. `clk_ok` is a status output. It falls once the synchronized level has stayed the same for `LOSS_CYC` reference cycles in a row. With the defaults, 20 reference cycles equal two periods of a 10 MHz clock seen from 100 MHz. `clk_ok` rises again on the first change seen afterwards. `win_err` grades short dropouts. Reference time is split into slots of `HALF_CYC` cycles, one nominal slow half-period each, and the slots are grouped in windows of `WIN_HALVES`. At the end of each window the block counts how many slots held at least one level change. Losing up to `MAX_MISS` slots is tolerated. A larger loss sets the flag until the next window ends.

Top module: `clk_loss_detector`

## Requirements
- R1: While `rst` is high at a rising reference edge, the block goes to `clk_ok` = 1 and `win_err` = 0, and it clears all counters, the slot phase and the synchronizer.
- R2: A level driven on `mon_clk` before reference edge n is first compared as a change at edge n+SYNC_STAGES. Its effect on both outputs is registered at that edge.
- R3: `clk_ok` is 0 after any edge where the last `LOSS_CYC` edges (default 20) each saw no level change. Otherwise it is 1.
- R4: The no-change counter saturates at `LOSS_CYC`. Because it cannot wrap, `clk_ok` stays 0 for any length of stop.
- R5: The first level change after a loss drives `clk_ok` to 1 at that same edge.
- R6: Slots are `HALF_CYC` edges long (default 5), counted from the first edge after reset, and `WIN_HALVES` slots (default 4) form a window. A slot counts as a hit when any of its edges saw a level change.
- R7: `win_err` changes only at the last edge of a window. At every other edge it holds its value.
- R8: At the end of a window `win_err` becomes 1 when the hit count is below `WIN_HALVES - MAX_MISS` (default: 2, 1 or 0 hits), and 0 for 3 or 4 hits.
- R9: Elaboration fails if `LOSS_CYC` is not larger than `HALF_CYC`, or if `MAX_MISS` is not smaller than `WIN_HALVES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, always running |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored slow clock, asynchronous to `clk` |
| clk_ok | output | 1 | 1 while the monitored clock is toggling, 0 after a loss |
| win_err | output | 1 | 1 when the last finished window lost too many slots |

## Verification
A level driven on `mon_clk` at a falling reference edge reaches the comparison two rising edges later. Both registered outputs therefore show its effect just after that rising edge. `win_err` moves only at a rising edge where the edge count since reset, modulo 20, is 19. The bench drives `mon_clk` and compares both outputs only at falling edges. A reference model that is advanced once per cycle predicts both outputs. It is built from the latency, counter and slot rules and shares nothing with the design. The stimulus sweeps every slot offset of a nominal 10-cycle toggle against zero to four missing slots. It also covers a long stop, toggling on every cycle, and a reset in the middle of the run.

// File: rtl/cld_pkg.sv
package cld_pkg;
  // Bits needed to hold values 0..n inclusive.
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cld_sync.sv
module cld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic chg_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign chg_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cld_stall.sv
module cld_stall #(
  parameter int LOSS_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic chg_i,
  output logic ok_o
);
  import cld_pkg::*;
  localparam int CW = cnt_bits(LOSS_CYC);
  localparam logic [CW-1:0] LIM = CW'(LOSS_CYC);

  logic [CW-1:0] quiet_q, quiet_n;
  logic          ok_q;

  always_comb begin
    if (chg_i)              quiet_n = '0;
    else if (quiet_q == LIM) quiet_n = LIM;
    else                    quiet_n = quiet_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= '0;
      ok_q    <= 1'b1;
    end else begin
      quiet_q <= quiet_n;
      ok_q    <= (quiet_n < LIM);
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/cld_window.sv
module cld_window #(
  parameter int HALF_CYC   = 5,
  parameter int WIN_HALVES = 4,
  parameter int MAX_MISS   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic chg_i,
  output logic err_o,
  output logic win_end_o
);
  import cld_pkg::*;
  localparam int PW = cnt_bits(HALF_CYC);
  localparam int HW = cnt_bits(WIN_HALVES);
  localparam logic [PW-1:0] PH_LAST  = PW'(HALF_CYC - 1);
  localparam logic [HW-1:0] HF_LAST  = HW'(WIN_HALVES - 1);
  localparam logic [HW-1:0] PASS_MIN = HW'(WIN_HALVES - MAX_MISS);

  logic [PW-1:0] phase_q;
  logic [HW-1:0] half_q, tally_q, tally_n;
  logic          seen_q, err_q, slot_end, hit;

  assign slot_end  = (phase_q == PH_LAST);
  assign win_end_o = slot_end && (half_q == HF_LAST);
  assign hit       = seen_q | chg_i;
  assign tally_n   = tally_q + HW'(hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      half_q  <= '0;
      tally_q <= '0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (slot_end) begin
      phase_q <= '0;
      seen_q  <= 1'b0;
      if (half_q == HF_LAST) begin
        half_q  <= '0;
        tally_q <= '0;
        err_q   <= (tally_n < PASS_MIN);
      end else begin
        half_q  <= half_q + 1'b1;
        tally_q <= tally_n;
      end
    end else begin
      phase_q <= phase_q + 1'b1;
      seen_q  <= hit;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/clk_loss_detector.sv
module clk_loss_detector #(
  parameter int LOSS_CYC    = 20,
  parameter int HALF_CYC    = 5,
  parameter int WIN_HALVES  = 4,
  parameter int MAX_MISS    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_clk,
  output logic clk_ok,
  output logic win_err
);
  logic mon_chg;
  logic win_end;

  // R9: parameter sanity at elaboration
  generate
    if (LOSS_CYC <= HALF_CYC) begin : g_bad_loss
      $error("LOSS_CYC must exceed HALF_CYC");
    end
    if (MAX_MISS >= WIN_HALVES) begin : g_bad_miss
      $error("MAX_MISS must be below WIN_HALVES");
    end
  endgenerate

  cld_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(mon_clk), .chg_o(mon_chg)
  );

  cld_stall #(.LOSS_CYC(LOSS_CYC)) u_stall (
    .clk(clk), .rst(rst), .chg_i(mon_chg), .ok_o(clk_ok)
  );

  cld_window #(
    .HALF_CYC(HALF_CYC), .WIN_HALVES(WIN_HALVES), .MAX_MISS(MAX_MISS)
  ) u_win (
    .clk(clk), .rst(rst), .chg_i(mon_chg), .err_o(win_err), .win_end_o(win_end)
  );
endmodule

// File: rtl/clk_loss_detector_chk.sv
module clk_loss_detector_chk #(
  parameter int LOSS_CYC = 20
) (
  input logic clk,
  input logic rst,
  input logic mon_chg,
  input logic win_end,
  input logic clk_ok,
  input logic win_err
);
  int quiet_q;

  always_ff @(posedge clk) begin
    if (rst || mon_chg)         quiet_q <= 0;
    else if (quiet_q < LOSS_CYC) quiet_q <= quiet_q + 1;
  end

  a_r1_reset_state: assert property (@(posedge clk) rst |=> (clk_ok && !win_err));

  a_r3_loss_low: assert property (@(posedge clk) disable iff (rst)
    (quiet_q == LOSS_CYC) |-> !clk_ok);

  a_r4_stay_low: assert property (@(posedge clk) disable iff (rst)
    (!clk_ok && !mon_chg) |=> !clk_ok);

  a_r5_recover: assert property (@(posedge clk) disable iff (rst)
    mon_chg |=> clk_ok);

  a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(win_err));
endmodule

bind clk_loss_detector clk_loss_detector_chk #(.LOSS_CYC(LOSS_CYC)) u_chk (
  .clk(clk), .rst(rst), .mon_chg(mon_chg), .win_end(win_end),
  .clk_ok(clk_ok), .win_err(win_err)
);

// File: tb/clk_loss_detector_tb.sv
module clk_loss_detector_tb;
  localparam int LOSS = 20;
  localparam int HALF = 5;
  localparam int WIN  = 4;
  localparam int MISS = 1;
  localparam int STG  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon = 1'b0;
  logic ok, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit h [STG+2];
  int quiet, n, tally, saw_err, saw_pass, saw_low;
  bit seen, e_ok, e_err, lvl;

  always #4 clk = ~clk;

  clk_loss_detector #(
    .LOSS_CYC(LOSS), .HALF_CYC(HALF), .WIN_HALVES(WIN),
    .MAX_MISS(MISS), .SYNC_STAGES(STG)
  ) u_dut (
    .clk(clk), .rst(rst), .mon_clk(mon), .clk_ok(ok), .win_err(err)
  );

  task automatic cmp(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at edge %0d", tag, act, exp, n);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < STG + 2; i++) h[i] = 1'b0;
    quiet = 0; n = 0; tally = 0; seen = 0; e_ok = 1; e_err = 0; lvl = 0;
  endtask

  // Called at a falling edge: check, drive, predict the next rising edge.
  task automatic step(input bit v);
    bit c, hit;
    cmp(ok,  e_ok,  "R2 R3 R4 R5 clk_ok");
    cmp(err, e_err, "R6 R7 R8 win_err");
    mon = v;
    for (int i = STG + 1; i > 0; i--) h[i] = h[i-1];
    h[0] = v;
    c = (h[STG] != h[STG+1]);
    quiet = c ? 0 : ((quiet < LOSS) ? quiet + 1 : LOSS);
    e_ok = (quiet < LOSS);
    if (!e_ok) saw_low++;
    if ((n % HALF) == HALF - 1) begin
      hit = seen || c;
      tally += int'(hit);
      seen = 0;
      if (((n / HALF) % WIN) == WIN - 1) begin
        e_err = (tally < WIN - MISS);
        if (e_err) saw_err++; else saw_pass++;
        tally = 0;
      end
    end else begin
      seen = seen || c;
    end
    n++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    mon = 1'b0;
    repeat (STG + 2) @(negedge clk);
    cmp(ok,  1'b1, "R1 reset clk_ok");
    cmp(err, 1'b0, "R1 reset win_err");
    rst = 1'b0;
    model_reset();
  endtask

  task automatic halves(input int k);
    repeat (k) begin
      lvl = !lvl;
      repeat (HALF) step(lvl);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    saw_err = 0; saw_pass = 0; saw_low = 0;
    @(negedge clk);
    do_reset();
    // R6 R8: every slot offset against 0..4 missing slots
    for (int off = 0; off < HALF; off++) begin
      for (int m = 0; m <= 4; m++) begin
        repeat (off) step(lvl);
        halves(10);
        repeat (HALF * m) step(lvl);
        halves(10);
      end
    end
    // R4: long stop, then R5 recovery
    repeat (100) step(lvl);
    halves(8);
    // toggling on every cycle
    repeat (30) begin
      lvl = !lvl;
      step(lvl);
    end
    // R1: reset mid-run, then nominal toggling again
    do_reset();
    halves(12);
    cmp(ok,  e_ok,  "R3 final clk_ok");
    cmp(err, e_err, "R8 final win_err");
    cmp(saw_err  > 0, 1'b1, "R8 error window reached");
    cmp(saw_pass > 0, 1'b1, "R8 passing window reached");
    cmp(saw_low  > 0, 1'b1, "R4 loss reached");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule